// File: doc/BRIEF.md
# External Bus Read Sequencer

This block converts single-byte read requests from inside the chip into read cycles on an external bus. The bus has separate lines for address and data: a 24-bit address and 8 data bits. Each request carries an address and a flag that marks it as a memory access or an I/O access. The block places the address on the bus and pulls chip select low. It pulses an address-latch enable, then asserts the read strobe together with either the memory-request or the I/O-request strobe. It stretches the cycle while the external READY line is low, captures the returned byte, and hands it back with a single-clock done pulse.

A bus cycle is built from bus states. Each bus state lasts two clocks of `clk`, a first half and a second half, so the address-latch enable can fall in the middle of a state. A read goes through T1, T2, an optional run of wait states, T3 and T4. The requester holds `req_valid` and the address fields stable. The request is taken on a clock where `req_ready` is high, which only happens in the second half of an idle bus state.

Top module: `ext_read_seq`

## Requirements
- R1: While `rst` is high and in the first clock after it, `cs_n`, `rd_n`, `mreq_n` and `iorq_n` are 1, `ale` is 0 and `rd_done` is 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) starts T1 on the next clock. With no wait states the sequence T1, T2, T3, T4 takes exactly 8 clocks, two per bus state, and the bus is idle afterwards.
- R3: From T1 through T3, including any wait states, `bus_addr` equals the accepted address and `cs_n` is 0. `cs_n` is 1 at all other times.
- R4: `ale` is 1 only during the first clock of T1 and is 0 in every other clock.
- R5: `rd_n` is 0 from the start of T2 to the end of T3, including any wait states, and is 1 at all other times.
- R6: During the same window as R5, `mreq_n` is 0 when `req_is_io` was 0, and `iorq_n` is 0 when `req_is_io` was 1. The two are never 0 together.
- R7: `ready` is sampled at the clock edge that ends the second half of T2 and of each wait state. A 0 there inserts one more two-clock wait state before T3. The strobes and `bus_addr` do not change during wait states.
- R8: `bus_data_in` is captured at the clock edge that ends T3. The captured byte appears on `rd_data`, and `rd_done` is 1 for exactly the first clock of T4.
- R9: In T4, `cs_n`, `rd_n`, `mreq_n` and `iorq_n` are all 1.
- R10: `req_ready` is 1 only in the second clock of an idle bus state. A `req_valid` raised and dropped while a cycle is in progress has no effect: no new cycle starts and `bus_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per bus state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request pending |
| req_ready | output | 1 | Request is taken on this clock if valid |
| req_addr | input | 24 | Read address |
| req_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| bus_addr | output | 24 | External address bus |
| bus_data_in | input | 8 | External data bus |
| cs_n | output | 1 | Chip select, active low |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| mreq_n | output | 1 | Memory request strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| ready | input | 1 | External ready, 0 requests wait states |
| rd_data | output | 8 | Captured read byte |
| rd_done | output | 1 | One-clock pulse with valid read byte |

## Verification
The bench checks every output on every clock of a cycle against the expected shape. A design with `ale` a clock too long, or with the read strobe starting in T1, shows up at once. Wait-state runs of zero, one and several states test whether READY is sampled on the correct edge; a design that samples in the first half, or ignores the last low sample, gets the cycle length wrong. The bench drives the data bus with a decoy value in every clock except the one that ends T3, so capturing a clock early or late returns the wrong byte. A stray request pulse in the middle of a cycle catches a design that restarts or reloads the address while busy.

// File: rtl/ext_read_seq_pkg.sv
package ext_read_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic cs_n;
        logic ale;
        logic rd_n;
        logic mreq_n;
        logic iorq_n;
    } bus_strobes_t;

    localparam bus_strobes_t STROBES_IDLE = '{cs_n: 1'b1, ale: 1'b0, rd_n: 1'b1,
                                             mreq_n: 1'b1, iorq_n: 1'b1};

    // Bus states in which the read strobe and address space strobe are active
    function automatic logic in_read_window(input bus_state_e st);
        return (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
    endfunction

    function automatic bus_strobes_t strobes_for(input bus_state_e st,
                                                 input logic second_half,
                                                 input logic is_io);
        bus_strobes_t s;
        s = STROBES_IDLE;
        if (st == ST_T1) begin
            s.cs_n = 1'b0;
            s.ale  = ~second_half;
        end else if (in_read_window(st)) begin
            s.cs_n   = 1'b0;
            s.rd_n   = 1'b0;
            s.mreq_n = is_io;
            s.iorq_n = ~is_io;
        end
        return s;
    endfunction

endpackage

// File: rtl/ext_read_seq_phase.sv
module ext_read_seq_phase (
    input  logic clk,
    input  logic rst,
    output logic second_half
);
    always_ff @(posedge clk) begin
        if (rst) second_half <= 1'b0;
        else     second_half <= ~second_half;
    end
endmodule

// File: rtl/ext_read_seq_fsm.sv
module ext_read_seq_fsm
    import ext_read_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              second_half,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    input  logic              ready,
    input  logic [DATA_W-1:0] data_in,
    output logic              req_ready,
    output bus_state_e        state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              is_io_q,
    output logic [DATA_W-1:0] data_q
);
    bus_state_e state_d;
    logic       accept;
    logic       capture;

    assign req_ready = (state_q == ST_IDLE) && second_half;
    assign accept    = req_ready && req_valid;
    assign capture   = (state_q == ST_T3) && second_half;

    always_comb begin
        state_d = state_q;
        if (second_half) begin
            unique case (state_q)
                ST_IDLE: if (req_valid) state_d = ST_T1;
                ST_T1:   state_d = ST_T2;
                ST_T2,
                ST_TW:   state_d = ready ? ST_T3 : ST_TW;
                ST_T3:   state_d = ST_T4;
                ST_T4:   state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            is_io_q <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                is_io_q <= req_is_io;
            end
            if (capture) data_q <= data_in;
        end
    end

    // R7
    wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (second_half && (state_q == ST_T2 || state_q == ST_TW) && !ready) |=> (state_q == ST_TW));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TW) |-> ($stable(addr_q) && $stable(is_io_q)));

    // R10
    accept_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (state_q == ST_T1));

endmodule

// File: rtl/ext_read_seq_strobes.sv
module ext_read_seq_strobes
    import ext_read_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_state_e state_q,
    input  logic       second_half,
    input  logic       is_io,
    output logic       cs_n,
    output logic       ale,
    output logic       rd_n,
    output logic       mreq_n,
    output logic       iorq_n,
    output logic       done
);
    bus_strobes_t s;

    always_comb begin
        s      = strobes_for(state_q, second_half, is_io);
        cs_n   = s.cs_n;
        ale    = s.ale;
        rd_n   = s.rd_n;
        mreq_n = s.mreq_n;
        iorq_n = s.iorq_n;
        done   = (state_q == ST_T4) && !second_half;
    end

    // R4
    ale_half_chk: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R6
    one_space_chk: assert property (@(posedge clk) disable iff (rst)
        !(mreq_n == 1'b0 && iorq_n == 1'b0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/ext_read_seq.sv
module ext_read_seq
    import ext_read_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              cs_n,
    output logic              ale,
    output logic              rd_n,
    output logic              mreq_n,
    output logic              iorq_n,
    input  logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    logic       second_half;
    bus_state_e state_q;
    logic       is_io_q;

    ext_read_seq_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .second_half (second_half)
    );

    ext_read_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .second_half (second_half),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_is_io   (req_is_io),
        .ready       (ready),
        .data_in     (bus_data_in),
        .req_ready   (req_ready),
        .state_q     (state_q),
        .addr_q      (bus_addr),
        .is_io_q     (is_io_q),
        .data_q      (rd_data)
    );

    ext_read_seq_strobes u_strobes (
        .clk         (clk),
        .rst         (rst),
        .state_q     (state_q),
        .second_half (second_half),
        .is_io       (is_io_q),
        .cs_n        (cs_n),
        .ale         (ale),
        .rd_n        (rd_n),
        .mreq_n      (mreq_n),
        .iorq_n      (iorq_n),
        .done        (rd_done)
    );

    // R5
    rd_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !cs_n);

endmodule

// File: tb/tb_ext_read_seq.sv
`timescale 1ns/1ps
module tb_ext_read_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_addr;
    logic        req_is_io;
    logic [23:0] bus_addr;
    logic [7:0]  bus_data_in;
    logic        cs_n, ale, rd_n, mreq_n, iorq_n;
    logic        ready;
    logic [7:0]  rd_data;
    logic        rd_done;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ext_read_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_is_io(req_is_io), .bus_addr(bus_addr),
        .bus_data_in(bus_data_in), .cs_n(cs_n), .ale(ale), .rd_n(rd_n),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .ready(ready), .rd_data(rd_data),
        .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Packs cs_n, ale, rd_n, mreq_n, iorq_n, rd_done
    function automatic logic [5:0] pins();
        return {cs_n, ale, rd_n, mreq_n, iorq_n, rd_done};
    endfunction

    task automatic test_reset();
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0;
        ready = 1'b1; bus_data_in = 8'h00;
        repeat (3) @(negedge clk);
        chk(pins() == 6'b101110, "R1", "strobes in reset", pins(), 6'b101110);
        rst = 1'b0;
        @(negedge clk);
        chk(pins() == 6'b101110, "R1", "strobes after reset", pins(), 6'b101110);
    endtask

    // One read with a given wait count; optionally a stray request pulse mid-cycle
    task automatic do_read(input logic [23:0] a, input bit io, input int waits,
                           input logic [7:0] d, input bit stray);
        int total;
        int seg;
        bit h;
        bit act_win, rd_win;
        logic [5:0] exp;
        total = 8 + 2 * waits;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_io = io;
        ready = 1'b1; bus_data_in = ~d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        for (int idx = 0; idx < total; idx++) begin
            seg = idx / 2;
            h   = idx[0];
            // stray request pulse while busy (R10)
            if (stray && idx == 3) begin req_valid = 1'b1; req_addr = 24'h0F0F0F; end
            if (stray && idx == 4) req_valid = 1'b0;
            // READY sampled at end of T2 and each wait state (R7)
            if (h && seg >= 1 && seg <= 1 + waits) ready = (seg == 1 + waits);
            else ready = 1'b1;
            // data valid only in last clock of T3 (R8)
            bus_data_in = (h && seg == 2 + waits) ? d : ~d;
            act_win = (seg <= 2 + waits);
            rd_win  = (seg >= 1) && act_win;
            exp = {~act_win, (seg == 0 && !h), ~rd_win, ~(rd_win && !io),
                   ~(rd_win && io), (seg == 3 + waits && !h)};
            #0.5;
            chk(pins() == exp, "R2 R3 R4 R5 R6 R9", $sformatf("strobes clk %0d", idx), pins(), exp);
            if (act_win)
                chk(bus_addr == a, "R3 R7", "address held", bus_addr, a);
            if (seg == 3 + waits && !h)
                chk(rd_data == d, "R8", "captured byte", rd_data, d);
            @(negedge clk);
        end
        ready = 1'b1;
        // Idle state: first clock not ready, second clock ready (R10)
        chk(req_ready == 1'b0 && cs_n == 1'b1, "R10", "idle first half", {req_ready, cs_n}, 2'b01);
        @(negedge clk);
        chk(req_ready == 1'b1 && cs_n == 1'b1, "R10", "idle second half", {req_ready, cs_n}, 2'b11);
        if (stray)
            chk(bus_addr == a, "R10", "stray request ignored", bus_addr, a);
    endtask

    task automatic test_mem_nowait();
        do_read(24'h123456, 1'b0, 0, 8'hA5, 1'b0);
    endtask

    task automatic test_io_nowait();
        do_read(24'h0000FF, 1'b1, 0, 8'h3C, 1'b0);
    endtask

    task automatic test_waits();
        do_read(24'hFFFFFF, 1'b0, 1, 8'h81, 1'b0);
        do_read(24'h800001, 1'b1, 3, 8'h7E, 1'b0);
    endtask

    task automatic test_stray();
        do_read(24'hABCDEF, 1'b0, 2, 8'hC3, 1'b1);
        // After dropping req_valid, nothing starts for a full bus state
        repeat (4) begin
            @(negedge clk);
            chk(cs_n == 1'b1 && ale == 1'b0, "R10", "no cycle without request",
                {cs_n, ale}, 2'b10);
        end
    endtask

    task automatic test_back_to_back();
        do_read(24'h000000, 1'b0, 0, 8'h00, 1'b0);
        do_read(24'h5A5A5A, 1'b1, 0, 8'hFF, 1'b0);
    endtask

    initial begin
        test_reset();
        test_mem_nowait();
        test_io_nowait();
        test_waits();
        test_stray();
        test_back_to_back();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule